// File: doc/BRIEF.md
# EEPROM Write Control Sequencer

This block holds the control register of an on-chip EEPROM and runs the programming sequence that commits data into the array. Software sets a write-enable bit and then writes a data byte. That single byte is programmed after a fixed number of cycles. In parallel mode, software first sets a parallel-enable bit and writes up to 16 bytes of one row into a row buffer. It then sets a start bit, and all buffered bytes are programmed in one operation.

While programming is in progress, a read-only busy flag is high and every array access is discarded. A standby bit powers the array down and blocks all access. After standby is cleared, access stays blocked for a short, fixed wake-up time. At the end of each programming operation, an interrupt request can be raised. While interrupts from this block are enabled, they take over an external interrupt line, which is then masked. The array is modelled as a plain byte array. Programming time is a fixed cycle count.

Top module: `eeprom_wr_seq`

## Requirements
- R1: After reset, the control register reads 00h, busy is low, the interrupt request is low and every array byte reads 00h.
- R2: Control register layout, bit 7 down to bit 0: constant 0, verify, standby, irq_en, par_start, par_en, busy, wr_en. Bit 7 always reads 0. Verify, standby, irq_en and wr_en read back the last value written.
- R3: The busy bit (bit 1) ignores register writes and goes high only when a programming operation starts.
- R4: While busy is high, data writes to the array are discarded and array reads return 00h.
- R5: While wr_en is 0, a data write leaves both the array and busy unchanged.
- R6: With wr_en=1 and par_en=0, a data write starts programming. Busy is high for PROG_CYCLES cycles, and then the byte reads back at its address.
- R7: With wr_en=1 and par_en=1, data writes fill a 16-entry buffer indexed by address bits [3:0], and the row is taken from the upper bits of the latest write. On start, only the bytes that were written are committed. The other bytes of the row keep their old values.
- R8: Writing 1 to par_start (bit 3) takes effect only if par_en read 1 before that write. A start runs parallel programming. At its end, both par_start and par_en clear themselves.
- R9: When irq_en (bit 4) is 1 at the end of a programming operation, irq goes high. It stays high until an irq_clr pulse. A new end event in the same cycle as irq_clr wins.
- R10: The int4_out output follows ext_int4 while irq_en is 0, and is held low while irq_en is 1.
- R11: While standby (bit 5) is 1, array reads return 00h and data writes are discarded. The same holds for WAKE_CYCLES cycles after the register write that clears standby.
- R12: While busy is high, register writes do not change par_en or par_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read value |
| mem_we | input | 1 | Array data write strobe |
| mem_addr | input | ADDR_W | Array data write address |
| mem_wdata | input | 8 | Array data write byte |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Array read byte, 00h while access is blocked |
| busy | output | 1 | Programming in progress |
| irq | output | 1 | End-of-write interrupt request |
| irq_clr | input | 1 | Write-1-to-clear pulse for irq |
| ext_int4 | input | 1 | External interrupt line shared with this block |
| int4_out | output | 1 | External interrupt after masking by irq_en |
| standby | output | 1 | Array power-down state |

## Verification
The embedded properties check, on every cycle, these rules:
- busy never rises without a start.
- A disabled data write never starts programming.
- A start only follows a set par_en.
- Both parallel bits are clear when busy falls.
- irq is raised at that point when irq_en was set.
- Reads are blocked at the moment standby is left.

Some behaviour only the bench scenarios can show, using a behavioural model compared on every clock:
- which bytes actually land in the array, including partial rows and aborted writes during busy or wake-up;
- the exact length of the busy and wake-up windows;
- the priority between irq_clr and a new end event.

// File: rtl/eeprom_wr_seq.sv
module eeprom_wr_seq #(
  parameter int ADDR_W      = 9,
  parameter int PROG_CYCLES = 8,
  parameter int WAKE_CYCLES = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              mem_we,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_wdata,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              busy,
  output logic              irq,
  input  logic              irq_clr,
  input  logic              ext_int4,
  output logic              int4_out,
  output logic              standby
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int ROW_W = ADDR_W - 4;
  localparam int CW    = $clog2(PROG_CYCLES + 1);
  localparam int WW    = $clog2(WAKE_CYCLES + 1);

  logic verify, stby, irq_en, par_start, par_en, wr_en, par_mode;
  logic [CW-1:0]     prog_cnt;
  logic [WW-1:0]     wake_cnt;
  logic [ADDR_W-1:0] s_addr;
  logic [7:0]        s_data;
  logic [ROW_W-1:0]  row_q;
  logic [15:0]       rvalid;
  logic [7:0]        rbuf [16];
  logic [7:0]        mem  [DEPTH];

  logic blocked, accept, done, start_par;
  assign blocked   = busy | stby | (wake_cnt != '0);
  assign accept    = mem_we & ~blocked & wr_en;
  assign done      = busy & (prog_cnt == CW'(1));
  assign start_par = reg_we & ~busy & reg_wdata[3] & par_en;

  assign reg_rdata = {1'b0, verify, stby, irq_en, par_start, par_en, busy, wr_en};
  assign rd_data   = blocked ? 8'h00 : mem[rd_addr];
  assign int4_out  = ext_int4 & ~irq_en;
  assign standby   = stby;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      verify <= 1'b0; stby <= 1'b0; irq_en <= 1'b0; wr_en <= 1'b0;
      par_start <= 1'b0; par_en <= 1'b0; busy <= 1'b0; par_mode <= 1'b0;
      prog_cnt <= '0; wake_cnt <= '0; s_addr <= '0; s_data <= '0; irq <= 1'b0;
    end else begin
      if (reg_we) begin
        verify <= reg_wdata[6];
        stby   <= reg_wdata[5];
        irq_en <= reg_wdata[4];
        wr_en  <= reg_wdata[0];
      end
      if (reg_we && stby && !reg_wdata[5]) wake_cnt <= WW'(WAKE_CYCLES);
      else if (wake_cnt != '0)              wake_cnt <= wake_cnt - 1'b1;

      if (done) begin
        par_en <= 1'b0;
        par_start <= 1'b0;
      end else if (reg_we && !busy) begin
        par_en    <= reg_wdata[2];
        par_start <= start_par;
      end

      if (done) begin
        busy <= 1'b0;
      end else if (start_par) begin
        busy <= 1'b1; par_mode <= 1'b1; prog_cnt <= CW'(PROG_CYCLES);
      end else if (accept && !par_en) begin
        busy <= 1'b1; par_mode <= 1'b0; prog_cnt <= CW'(PROG_CYCLES);
        s_addr <= mem_addr; s_data <= mem_wdata;
      end else if (busy) begin
        prog_cnt <= prog_cnt - 1'b1;
      end

      if (done && irq_en) irq <= 1'b1;
      else if (irq_clr)   irq <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
      for (int i = 0; i < 16; i++) rbuf[i] <= 8'h00;
      rvalid <= '0;
      row_q  <= '0;
    end else begin
      if (done && par_mode) begin
        for (int i = 0; i < 16; i++)
          if (rvalid[i]) mem[{row_q, 4'(i)}] <= rbuf[i];
      end else if (done) begin
        mem[s_addr] <= s_data;
      end
      if (done || !par_en) begin
        rvalid <= '0;
      end else if (accept) begin
        rvalid[mem_addr[3:0]] <= 1'b1;
        rbuf[mem_addr[3:0]]   <= mem_wdata;
        row_q                 <= mem_addr[ADDR_W-1:4];
      end
    end
  end

  p_busy_ro_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !mem_we && !reg_we) |=> !busy);
  p_wen_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && mem_we && !wr_en && !reg_we) |=> !busy);
  p_start_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(par_start) |-> $past(par_en));
  p_par_autoclear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (!par_en && !par_start));
  p_irq_on_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && $past(irq_en)) |-> irq);
  p_wake_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stby) |-> (rd_data == 8'h00));
endmodule

// File: tb/test_eeprom_wr_seq.sv
module test_eeprom_wr_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 9;
  localparam int P  = 8;
  localparam int WK = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 0, mem_we = 0, irq_clr = 0, ext_int4 = 0;
  logic [7:0] reg_wdata = 0, mem_wdata = 0;
  logic [AW-1:0] mem_addr = 0, rd_addr = 0;
  logic [7:0] reg_rdata, rd_data;
  logic busy, irq, int4_out, standby;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_wr_seq #(.ADDR_W(AW), .PROG_CYCLES(P), .WAKE_CYCLES(WK)) i_eeprom_wr_seq (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(busy), .irq(irq), .irq_clr(irq_clr), .ext_int4(ext_int4),
    .int4_out(int4_out), .standby(standby));

  int mm [1 << AW];
  int bq [16];
  bit vq [16];
  int m_row, m_cnt, m_wake, m_addr, m_data;
  bit m_ver, m_stb, m_ien, m_pst, m_pen, m_busy, m_wen, m_par, m_irq;

  function automatic bit m_blocked();
    return m_busy || m_stb || (m_wake > 0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mm[i]) mm[i] = 0;
      foreach (vq[i]) vq[i] = 0;
      m_ver = 0; m_stb = 0; m_ien = 0; m_pst = 0; m_pen = 0; m_busy = 0;
      m_wen = 0; m_par = 0; m_irq = 0; m_cnt = 0; m_wake = 0; m_row = 0;
    end else begin
      bit ob, open, ostb, oien, owen, blk, fin, st;
      ob = m_busy; open = m_pen; ostb = m_stb; oien = m_ien; owen = m_wen;
      blk = m_blocked();
      fin = ob && m_cnt == 1;
      st = reg_we && !ob && reg_wdata[3] && open;
      if (fin) begin
        if (m_par) begin
          for (int i = 0; i < 16; i++) if (vq[i]) mm[m_row*16 + i] = bq[i];
        end else mm[m_addr] = m_data;
      end
      if (fin || !open) foreach (vq[i]) vq[i] = 0;
      else if (mem_we && !blk && owen) begin
        vq[mem_addr[3:0]] = 1; bq[mem_addr[3:0]] = mem_wdata; m_row = mem_addr >> 4;
      end
      if (reg_we) begin
        m_ver = reg_wdata[6]; m_stb = reg_wdata[5]; m_ien = reg_wdata[4]; m_wen = reg_wdata[0];
      end
      if (reg_we && ostb && !reg_wdata[5]) m_wake = WK;
      else if (m_wake > 0) m_wake--;
      if (fin) begin m_pen = 0; m_pst = 0; end
      else if (reg_we && !ob) begin m_pen = reg_wdata[2]; m_pst = st; end
      if (fin) m_busy = 0;
      else if (st) begin m_busy = 1; m_par = 1; m_cnt = P; end
      else if (mem_we && !blk && owen && !open) begin
        m_busy = 1; m_par = 0; m_cnt = P; m_addr = mem_addr; m_data = mem_wdata;
      end else if (ob) m_cnt--;
      if (fin && oien) m_irq = 1;
      else if (irq_clr) m_irq = 0;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    chk("R2 reg_rdata vs model", reg_rdata,
        {1'b0, m_ver, m_stb, m_ien, m_pst, m_pen, m_busy, m_wen});
    chk("R3 busy vs model", busy, m_busy);
    chk("R9 irq vs model", irq, m_irq);
    chk("R10 int4_out vs model", int4_out, ext_int4 & !m_ien);
    chk("R4 rd_data vs model", rd_data, m_blocked() ? 0 : mm[rd_addr]);
    chk("R11 standby vs model", standby, m_stb);
  end

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic wreg(logic [7:0] v);
    reg_we = 1; reg_wdata = v; tick(); reg_we = 0;
  endtask
  task automatic mwr(int a, logic [7:0] d);
    mem_we = 1; mem_addr = AW'(a); mem_wdata = d; tick(); mem_we = 0;
  endtask
  task automatic rd(int a, string req, int exp);
    rd_addr = AW'(a); #1; chk(req, rd_data, exp);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    #1;
    chk("R1 reset reg", reg_rdata, 8'h00);
    chk("R1 reset irq", irq, 0);
    rd(3, "R1 reset array", 8'h00);
    wreg(8'hD1);
    chk("R2 bit7 zero, fields readback", reg_rdata, 8'h51);
    wreg(8'h02);
    chk("R3 busy not writable", reg_rdata, 8'h00);
    chk("R3 busy low", busy, 0);
    mwr(5, 8'hAA);
    chk("R5 no busy when wr_en=0", busy, 0);
    rd(5, "R5 array unchanged", 8'h00);
    wreg(8'h01);
    mwr(5, 8'hAA);
    chk("R6 busy after data write", busy, 1);
    mwr(6, 8'h77);
    rd(5, "R4 read blocked while busy", 8'h00);
    repeat (P - 2) tick();
    chk("R6 busy still high", busy, 1);
    tick();
    chk("R6 busy done", busy, 0);
    rd(5, "R6 byte programmed", 8'hAA);
    rd(6, "R4 write during busy aborted", 8'h00);
    wreg(8'h09);
    chk("R8 start ignored without par_en", reg_rdata, 8'h01);
    wreg(8'h05);
    mwr(8'h23, 8'h11); mwr(8'h2F, 8'h22); mwr(8'h25, 8'h33);
    wreg(8'h0D);
    chk("R8 start accepted", reg_rdata, 8'h0F);
    wreg(8'h01);
    chk("R12 par bits held while busy", reg_rdata, 8'h0F);
    repeat (P - 1) tick();
    chk("R8 par bits cleared at end", reg_rdata, 8'h01);
    rd(8'h23, "R7 row byte 3", 8'h11);
    rd(8'h2F, "R7 row byte F", 8'h22);
    rd(8'h25, "R7 row byte 5", 8'h33);
    rd(8'h24, "R7 unwritten byte kept", 8'h00);
    ext_int4 = 1; #1;
    chk("R10 int4 passes", int4_out, 1);
    wreg(8'h11);
    chk("R10 int4 masked", int4_out, 0);
    mwr(9, 8'h5C);
    repeat (P) tick();
    chk("R9 irq raised", irq, 1);
    repeat (3) tick();
    chk("R9 irq held", irq, 1);
    irq_clr = 1; tick(); irq_clr = 0;
    chk("R9 irq cleared", irq, 0);
    wreg(8'h21);
    rd(9, "R11 read blocked in standby", 8'h00);
    mwr(10, 8'h44);
    wreg(8'h01);
    mwr(11, 8'h55);
    repeat (WK - 2) tick();
    rd(9, "R11 still blocked in wake", 8'h00);
    tick();
    rd(9, "R11 access after wake", 8'h5C);
    rd(10, "R11 standby write aborted", 8'h00);
    rd(11, "R11 wake write aborted", 8'h00);
    repeat (2) tick();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule